// File: doc/BRIEF.md
# Bus-attached word memory slave

This block is a single-cycle AHB-Lite slave that fronts a 32-bit-wide memory held in flip-flops inside the block. A master reaches it through the usual two-phase transfer. The block latches the control in the address phase, when `hsel` is asserted, `htrans` is active and `hready` is high. It performs the access in the following cycle, when write data is on `hwdata` or read data is due on `hrdata`. Transfers of 8, 16 and 32 bits are supported. The byte lanes written come from the transfer size and the two low address bits. A read always returns the full addressed word, and the master picks out the lane it needs.

The memory array runs on the falling edge of the bus clock. A write therefore lands in the middle of its data phase. A read in the next data phase samples the array at the following falling edge, so a read straight after a write to the same word returns the new value without a bypass path. The slave never stalls and never signals an error. Burst transfers are handled as a string of single transfers.

The default `ADDR_W` of 12 gives a 4 KB region of 1024 words. Setting it to 16 gives a 64 KB region of 16384 words.

Top module: `ahb_sram_slave`

## Requirements
- R1: A transfer is latched at the rising edge where `hsel`=1, `htrans[1]`=1 and `hready`=1. The access takes place in the next cycle, and a write takes its data from `hwdata` in that next cycle.
- R2: No memory write and no change of `hrdata` result from a cycle with `hsel`=0, `htrans`=2'b00 (IDLE) or `htrans`=2'b01 (BUSY).
- R3: The word index is `haddr[ADDR_W-1:2]`, and address bits at or above `ADDR_W` are ignored. With `ADDR_W`=12, addresses 0x0000_0010 and 0x0010_0010 reach the same word.
- R4: A byte write (`hsize`=3'b000) updates only lane `haddr[1:0]`: lane 0 is bits 7:0, lane 1 is bits 15:8, lane 2 is bits 23:16 and lane 3 is bits 31:24.
- R5: A halfword write (`hsize`=3'b001) updates bits 15:0 when `haddr[1:0]`=0 and bits 31:16 when `haddr[1:0]`=2.
- R6: A word write (`hsize`=3'b010) at `haddr[1:0]`=0 updates all 32 bits.
- R7: A halfword at an odd address, a word at a non-zero `haddr[1:0]`, or any `hsize` above 3'b010 writes nothing.
- R8: A read places the whole addressed word on `hrdata` from the middle of its data phase until the next read's data phase. Between reads, `hrdata` holds its value.
- R9: A read whose address phase coincides with the data phase of a write to the same word returns the newly written word.
- R10: `hready_resp` is 1 and `hresp` is 0 (OKAY) in every cycle.
- R11: While `hresetn` is low, the latched transfer is cleared and `hrdata` is 0. A write whose address phase was latched just before reset is not performed. Memory contents survive reset.
- R12: An address phase presented while `hready`=0 is not latched and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock; the memory array uses its falling edge |
| hresetn | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | 32 | Byte address |
| htrans | input | 2 | Transfer type (IDLE 00, BUSY 01, NONSEQ 10, SEQ 11) |
| hwrite | input | 1 | 1 = write, 0 = read |
| hsize | input | 3 | Transfer size (000 byte, 001 halfword, 010 word) |
| hready | input | 1 | Previous transfer complete on the bus |
| hwdata | input | 32 | Write data for the data phase |
| hrdata | output | 32 | Read data |
| hready_resp | output | 1 | Slave ready, always 1 |
| hresp | output | 1 | Response, always 0 (OKAY) |

## Verification
Two situations are hard to reach from the ports. The first is a read whose address phase overlaps the data phase of a write to the same word. The bench issues a write followed at once by a read of that word, with nothing between them. The second is a write cut off by reset after its address phase was latched but before its data phase. The bench asserts reset one cycle after that address phase. It then reads the word back and expects the value written earlier. A cycle-accurate reference model in the bench compares `hrdata` in every cycle, so any stray write or missed update shows up on a later read.

// File: rtl/ahb_sram_pkg.sv
`timescale 1ns/1ps
package ahb_sram_pkg;
  localparam logic [2:0] SZ_BYTE = 3'b000;
  localparam logic [2:0] SZ_HALF = 3'b001;
  localparam logic [2:0] SZ_WORD = 3'b010;
  localparam int LANES = 4;

  // Byte-lane strobes for a transfer; an unaligned or oversized transfer yields none.
  function automatic logic [LANES-1:0] lane_strobe(input logic [2:0] size, input logic [1:0] lo);
    logic [LANES-1:0] s;
    case (size)
      SZ_BYTE: s = 4'b0001 << lo;
      SZ_HALF: s = (lo == 2'b00) ? 4'b0011 : ((lo == 2'b10) ? 4'b1100 : 4'b0000);
      SZ_WORD: s = (lo == 2'b00) ? 4'b1111 : 4'b0000;
      default: s = 4'b0000;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/ahb_sram_aphase.sv
`timescale 1ns/1ps
module ahb_sram_aphase #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsel_i,
  input  logic [1:0]        htrans_i,
  input  logic              hwrite_i,
  input  logic [2:0]        hsize_i,
  input  logic              hready_i,
  input  logic [ADDR_W-1:0] haddr_i,
  output logic              dp_valid_o,
  output logic              dp_write_o,
  output logic [2:0]        dp_size_o,
  output logic [ADDR_W-1:0] dp_addr_o
);
  logic addr_take;
  logic unused_seq;

  assign unused_seq = htrans_i[0];
  assign addr_take  = hready_i && hsel_i && htrans_i[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_valid_o <= 1'b0;
      dp_write_o <= 1'b0;
      dp_size_o  <= '0;
      dp_addr_o  <= '0;
    end else if (hready_i) begin
      dp_valid_o <= addr_take;
      dp_write_o <= hwrite_i;
      dp_size_o  <= hsize_i;
      dp_addr_o  <= haddr_i;
    end else begin
      dp_valid_o <= 1'b0;
    end
  end

  AST_IDLE_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsel_i || !htrans_i[1]) |=> !dp_valid_o); // R2
  AST_STALL_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !hready_i |=> !dp_valid_o); // R12
  AST_PEND_FROM_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    dp_valid_o |-> $past(hsel_i) && $past(hready_i)); // R1
endmodule

// File: rtl/ahb_sram_mem.sv
`timescale 1ns/1ps
module ahb_sram_mem #(
  parameter int IDX_W = 10,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [LANES-1:0]   be_i,
  input  logic               rd_en_i,
  input  logic [8*LANES-1:0] wdata_i,
  output logic [8*LANES-1:0] rdata_o
);
  localparam int WORDS = 1 << IDX_W;

  logic [8*LANES-1:0] mem_q [WORDS];

  // Array updates on the falling edge, mid data phase.
  always_ff @(negedge clk) begin
    for (int b = 0; b < LANES; b++) begin
      if (be_i[b]) mem_q[idx_i][8*b +: 8] <= wdata_i[8*b +: 8];
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_o <= '0;
    else if (rd_en_i) rdata_o <= mem_q[idx_i];
  end

  AST_RD_HOLD: assert property (@(negedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_o)); // R8
  AST_NO_WRITE_ON_READ: assert property (@(negedge clk) disable iff (!rst_n)
    rd_en_i |-> be_i == '0); // R8
endmodule

// File: rtl/ahb_sram_slave.sv
`timescale 1ns/1ps
module ahb_sram_slave #(
  parameter int ADDR_W = 12
) (
  input  logic        hclk,
  input  logic        hresetn,
  input  logic        hsel,
  input  logic [31:0] haddr,
  input  logic [1:0]  htrans,
  input  logic        hwrite,
  input  logic [2:0]  hsize,
  input  logic        hready,
  input  logic [31:0] hwdata,
  output logic [31:0] hrdata,
  output logic        hready_resp,
  output logic        hresp
);
  import ahb_sram_pkg::*;

  localparam int IDX_W = ADDR_W - 2;

  logic              dp_valid;
  logic              dp_write;
  logic [2:0]        dp_size;
  logic [ADDR_W-1:0] dp_addr;
  logic [LANES-1:0]  wr_be;
  logic              rd_en;
  logic              unused_hi;

  assign unused_hi   = ^haddr[31:ADDR_W];
  assign hready_resp = 1'b1;
  assign hresp       = 1'b0;

  ahb_sram_aphase #(.ADDR_W(ADDR_W)) aphase_i (
    .clk        (hclk),
    .rst_n      (hresetn),
    .hsel_i     (hsel),
    .htrans_i   (htrans),
    .hwrite_i   (hwrite),
    .hsize_i    (hsize),
    .hready_i   (hready),
    .haddr_i    (haddr[ADDR_W-1:0]),
    .dp_valid_o (dp_valid),
    .dp_write_o (dp_write),
    .dp_size_o  (dp_size),
    .dp_addr_o  (dp_addr)
  );

  assign wr_be = (dp_valid && dp_write) ? lane_strobe(dp_size, dp_addr[1:0]) : '0;
  assign rd_en = dp_valid && !dp_write;

  ahb_sram_mem #(.IDX_W(IDX_W), .LANES(LANES)) mem_i (
    .clk     (hclk),
    .rst_n   (hresetn),
    .idx_i   (dp_addr[ADDR_W-1:2]),
    .be_i    (wr_be),
    .rd_en_i (rd_en),
    .wdata_i (hwdata),
    .rdata_o (hrdata)
  );

  AST_STROBE_SHAPE: assert property (@(posedge hclk) disable iff (!hresetn)
    $countones(wr_be) == 0 || $countones(wr_be) == 1 ||
    $countones(wr_be) == 2 || $countones(wr_be) == 4); // R4
  AST_MISALIGNED_NO_WRITE: assert property (@(posedge hclk) disable iff (!hresetn)
    (dp_size > SZ_WORD || (dp_size == SZ_HALF && dp_addr[0]) ||
     (dp_size == SZ_WORD && dp_addr[1:0] != 2'b00)) |-> wr_be == '0); // R7
  AST_WORD_ALL_LANES: assert property (@(posedge hclk) disable iff (!hresetn)
    (dp_valid && dp_write && dp_size == SZ_WORD && dp_addr[1:0] == 2'b00) |-> wr_be == 4'b1111); // R6
endmodule

// File: tb/ahb_sram_slave_tb_top.sv
`timescale 1ns/1ps
module ahb_sram_slave_tb_top;
  localparam int AW = 12;

  logic        hclk = 1'b0;
  logic        hresetn = 1'b0;
  logic        hsel = 1'b0;
  logic [31:0] haddr = '0;
  logic [1:0]  htrans = 2'b00;
  logic        hwrite = 1'b0;
  logic [2:0]  hsize = 3'b000;
  logic        hready = 1'b1;
  logic [31:0] hwdata = '0;
  logic [31:0] hrdata;
  logic        hready_resp;
  logic        hresp;

  int n_tests = 0;
  int n_fail  = 0;

  // reference model state
  logic [31:0] refmem [int];
  logic        p_valid = 1'b0;
  logic        p_write = 1'b0;
  logic [2:0]  p_size  = '0;
  logic [31:0] p_addr  = '0;
  logic [31:0] p_wdata = '0;
  logic [31:0] exp_rd  = '0;
  logic        exp_known = 1'b1;

  always #2 hclk = ~hclk;

  ahb_sram_slave #(.ADDR_W(AW)) dut_i (
    .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hready(hready), .hwdata(hwdata),
    .hrdata(hrdata), .hready_resp(hready_resp), .hresp(hresp)
  );

  function automatic logic [3:0] lanes_for(input logic [2:0] sz, input logic [31:0] a);
    int off;
    off = int'(a[1:0]);
    if (sz == 3'd0) return 4'(1 << off);
    if (sz == 3'd1 && off == 0) return 4'b0011;
    if (sz == 3'd1 && off == 2) return 4'b1100;
    if (sz == 3'd2 && off == 0) return 4'b1111;
    return 4'b0000;
  endfunction

  task automatic check(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %08h expected %08h", tag, $time, act, expv);
    end
  endtask

  // One bus cycle: drive an address phase plus the data of the previous one,
  // then advance the model and compare after the falling edge.
  task automatic cyc(input string tag, input logic sel, input logic [1:0] tr, input logic wr,
                     input logic [2:0] sz, input logic [31:0] ad, input logic [31:0] wd,
                     input logic rdy = 1'b1);
    int idx;
    logic [31:0] w;
    logic [3:0] ln;
    @(posedge hclk);
    #1;
    hsel = sel; htrans = tr; hwrite = wr; hsize = sz; haddr = ad; hready = rdy;
    hwdata = p_wdata;
    #2;
    if (p_valid) begin
      idx = int'(p_addr[AW-1:2]);
      if (p_write) begin
        ln = lanes_for(p_size, p_addr);
        w = refmem.exists(idx) ? refmem[idx] : 32'h0;
        for (int b = 0; b < 4; b++) if (ln[b]) w[8*b +: 8] = p_wdata[8*b +: 8];
        if (ln != 4'b0000) refmem[idx] = w;
      end else begin
        exp_known = refmem.exists(idx);
        exp_rd = exp_known ? refmem[idx] : 32'h0;
      end
    end
    if (exp_known) check(tag, hrdata === exp_rd, hrdata, exp_rd);
    check("R10", hready_resp === 1'b1 && hresp === 1'b0, {30'd0, hready_resp, hresp}, 32'h2);
    p_valid = rdy && sel && tr[1];
    p_write = wr; p_size = sz; p_addr = ad; p_wdata = wd;
  endtask

  task automatic wr(input string tag, input logic [2:0] sz, input logic [31:0] a, input logic [31:0] d);
    cyc(tag, 1'b1, 2'b10, 1'b1, sz, a, d);
  endtask
  task automatic rd(input string tag, input logic [31:0] a);
    cyc(tag, 1'b1, 2'b10, 1'b0, 3'd2, a, 32'h0);
  endtask
  task automatic nop(input string tag);
    cyc(tag, 1'b0, 2'b00, 1'b0, 3'd0, 32'h0, 32'h0);
  endtask

  task automatic do_reset();
    @(posedge hclk);
    #1;
    hresetn = 1'b0; hsel = 1'b0; htrans = 2'b00;
    p_valid = 1'b0; exp_rd = '0; exp_known = 1'b1;
    #2;
    check("R11", hrdata === 32'h0, hrdata, 32'h0);
    @(posedge hclk);
    #1;
    hresetn = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge hclk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // reset state
    repeat (2) @(posedge hclk);
    #3;
    check("R11", hrdata === 32'h0, hrdata, 32'h0);
    check("R10", hready_resp === 1'b1 && hresp === 1'b0, {31'd0, hresp}, 32'h0);
    @(posedge hclk);
    #1;
    hresetn = 1'b1;

    // R6 back-to-back word writes, R8 reads
    for (int i = 0; i < 8; i++) wr("R6", 3'd2, 32'(i * 4), 32'hA500_0000 + 32'(i * 32'h0101_0101));
    for (int i = 0; i < 8; i++) rd("R8", 32'(i * 4));
    nop("R8"); nop("R8");

    // R4 byte lanes
    wr("R4", 3'd2, 32'h20, 32'h0000_0000);
    for (int b = 0; b < 4; b++) begin
      wr("R4", 3'd0, 32'h20 + 32'(b), {4{8'(8'h11 * (b + 1))}});
      rd("R4", 32'h20);
    end

    // R5 halfwords
    wr("R5", 3'd2, 32'h24, 32'hFFFF_FFFF);
    wr("R5", 3'd1, 32'h24, 32'h1234_5678);
    rd("R5", 32'h24);
    wr("R5", 3'd1, 32'h26, 32'h9ABC_DEF0);
    rd("R5", 32'h24);

    // R7 misaligned and oversized
    wr("R7", 3'd2, 32'h28, 32'h0F0F_0F0F);
    wr("R7", 3'd1, 32'h29, 32'hDEAD_BEEF);
    wr("R7", 3'd1, 32'h2B, 32'hDEAD_BEEF);
    wr("R7", 3'd2, 32'h29, 32'hDEAD_BEEF);
    wr("R7", 3'd2, 32'h2A, 32'hDEAD_BEEF);
    wr("R7", 3'd3, 32'h28, 32'hDEAD_BEEF);
    wr("R7", 3'd7, 32'h28, 32'hDEAD_BEEF);
    rd("R7", 32'h28);
    nop("R7");

    // R2 idle, busy and deselected cycles carry no write
    cyc("R2", 1'b1, 2'b00, 1'b1, 3'd2, 32'h28, 32'h1111_1111);
    cyc("R2", 1'b1, 2'b01, 1'b1, 3'd2, 32'h28, 32'h2222_2222);
    cyc("R2", 1'b0, 2'b10, 1'b1, 3'd2, 32'h28, 32'h3333_3333);
    cyc("R2", 1'b0, 2'b10, 1'b0, 3'd2, 32'h0, 32'h0);
    nop("R2");
    rd("R2", 32'h28);
    nop("R2");

    // R12 address phase while hready low
    cyc("R12", 1'b1, 2'b10, 1'b1, 3'd2, 32'h28, 32'h4444_4444, 1'b0);
    nop("R12");
    rd("R12", 32'h28);
    nop("R12");

    // R3 upper address bits ignored, top word of the region
    wr("R3", 3'd2, 32'h0010_0010, 32'hC0DE_0010);
    rd("R3", 32'h0000_0010);
    wr("R3", 3'd2, 32'(1 << AW) - 32'd4, 32'h7777_8888);
    rd("R3", 32'h8000_0000 + 32'(1 << AW) - 32'd4);
    nop("R3");

    // R9 read right after write to the same word, and R1 pipelining with SEQ
    wr("R9", 3'd2, 32'h30, 32'h1357_9BDF);
    rd("R9", 32'h30);
    wr("R9", 3'd0, 32'h31, 32'h0000_EE00);
    rd("R9", 32'h30);
    cyc("R1", 1'b1, 2'b11, 1'b1, 3'd2, 32'h34, 32'h2468_ACE0);
    cyc("R1", 1'b1, 2'b11, 1'b0, 3'd2, 32'h34, 32'h0);
    nop("R1"); nop("R1");

    // R11 write latched just before reset is dropped; memory kept
    wr("R11", 3'd2, 32'h38, 32'h5A5A_5A5A);
    nop("R11");
    wr("R11", 3'd2, 32'h38, 32'hBAD0_BAD0);
    do_reset();
    nop("R11");
    rd("R11", 32'h38);
    rd("R11", 32'h0);
    nop("R11"); nop("R11");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule